// File: doc/BRIEF.md
# Period Timer with Prescaler and Postscaler

This block is an up-counter that counts instruction-rate ticks and turns them into a regular event. A tick enable marks each instruction cycle. A selectable prescaler divides the ticks by 1, 4 or 16 before they reach the counter. The counter is compared against a period register. When an increment arrives while the count equals the period, the count returns to zero and a one-cycle match pulse is sent to a neighbouring PWM unit. The interval between matches is therefore the division ratio times (period + 1) ticks.

A 4-bit postscaler counts these matches and sets a sticky interrupt flag on every N-th match, where N runs from 1 to 16. Software uses three write strobes to load the count, load the period, or load the control word. The control word holds the run bit, the prescale select and the postscale select. The count and the internal prescaler count are both visible, so that a PWM comparator can use the prescaler bits as extra resolution.

Top module: `period_timer`

## Requirements
- R1: After the synchronous active-high reset, the count, the prescaler count, the match pulse and the interrupt flag are all zero, and the run bit is clear, so ticks do not advance the count.
- R2: The prescaler and the counter advance only in cycles where `tick` is high and the run bit (control bit 0) is set. Otherwise the count holds its value.
- R3: The prescale select sits in control bits 2:1. Code 00 divides by 1, code 01 by 4, and codes 10 and 11 by 16. The prescaler count reads back 0 up to ratio-1, and the counter steps when the prescaler count wraps.
- R4: When the counter steps while the count equals the period, the count becomes 0 and `match_o` is high for the next cycle. The interval between matches is ratio × (period + 1) ticks, and the first match after a count write of 0 comes that many ticks later.
- R5: A count above the period rolls through the maximum value to 0 with no match. A match follows only when the count next reaches the period.
- R6: The postscale select sits in control bits 6:3, with value S meaning 1:(S+1). The interrupt flag sets together with the (S+1)-th match pulse counted since the last count write.
- R7: The interrupt flag stays set until `irq_clr` is high. A clear in the same cycle as a new set leaves the flag clear.
- R8: A count write loads `wr_data` into the count and clears both the prescaler count and the postscaler count. It takes priority over an increment in the same cycle and produces no match.
- R9: A control write leaves the prescaler count and the postscaler count unchanged.
- R10: A period write takes effect for the comparisons that follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Instruction-cycle enable |
| wr_count | input | 1 | Load count from `wr_data`, clear prescaler and postscaler |
| wr_period | input | 1 | Load period register from `wr_data` |
| wr_ctrl | input | 1 | Load control word from `wr_data` (bit 0 run, 2:1 prescale, 6:3 postscale) |
| wr_data | input | CNT_W | Write data shared by the three strobes |
| irq_clr | input | 1 | Clear the interrupt flag |
| count_o | output | CNT_W | Current count |
| prescale_cnt_o | output | 4 | Current prescaler count |
| match_o | output | 1 | One-cycle pulse after a period match |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The hardest state to reach from the ports is a postscaler that has counted part of a group when a control or count write lands. The bench runs the period at zero with a 1:1 prescaler, so a match occurs on every cycle. This places a write after an exact number of counted matches, and the cycle in which the flag then rises shows whether the postscaler count survived the write. A sweep over every prescale code, several periods and several postscale ratios checks the time of the first match, the gap to the second match, and the time at which the flag first rises against products computed in the bench.

// File: rtl/pt_pkg.sv
package pt_pkg;

  // Fixed encodings of the control word
  localparam int CTRL_W  = 7;
  localparam int PRE_W   = 4;
  localparam int POST_W  = 4;

  typedef struct packed {
    logic [POST_W-1:0] post_sel;  // bits 6:3
    logic [1:0]        pre_sel;   // bits 2:1
    logic              on;        // bit 0
  } pt_ctrl_t;

  // Terminal prescaler count for a select code
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      2'b00:   r = PRE_W'(0);
      2'b01:   r = PRE_W'(3);
      default: r = PRE_W'(15);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs
  import pt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_period,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wr_data,
  output pt_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0] period_o
);

  pt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= pt_ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_period) period_q <= wr_data;
    end
  end

  // Bits above the control word carry no meaning
  generate
    if (CNT_W > CTRL_W) begin : g_spare
      logic unused_ctrl_bits;
      assign unused_ctrl_bits = ^wr_data[CNT_W-1:CTRL_W];
    end
  endgenerate

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;

endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler
  import pt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             clear,
  input  logic [1:0]       sel,
  output logic [PRE_W-1:0] cnt_o,
  output logic             step_o
);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;
  logic             at_end;

  assign last   = pre_last(sel);
  // >= so that a lowered ratio never waits for a full wrap
  assign at_end = (cnt_q >= last);
  assign step_o = tick_en && at_end && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= at_end ? '0 : cnt_q + PRE_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o,
  output logic             match_o
);

  logic [CNT_W-1:0] count_q;
  logic             match_q;
  logic             hit;

  assign hit    = (count_q == period_i);
  assign wrap_o = step_i && !load_i && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= wrap_o;
      if (load_i)
        count_q <= load_val_i;
      else if (step_i)
        count_q <= hit ? '0 : count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign match_o = match_q;

endmodule

// File: rtl/pt_postscaler.sv
module pt_postscaler
  import pt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  input  logic              clear,
  input  logic [POST_W-1:0] sel,
  input  logic              irq_clr,
  output logic              irq_o
);

  logic [POST_W-1:0] cnt_q;
  logic              irq_q;
  logic              done;
  logic              fire;

  assign done = (cnt_q >= sel);
  assign fire = evt_i && done;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      cnt_q <= done ? '0 : cnt_q + POST_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (irq_clr) irq_q <= 1'b0;
    else if (fire)    irq_q <= 1'b1;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/period_timer.sv
module period_timer
  import pt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_count,
  input  logic             wr_period,
  input  logic             wr_ctrl,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] count_o,
  output logic [PRE_W-1:0] prescale_cnt_o,
  output logic             match_o,
  output logic             irq_o
);

  pt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] period_q;
  logic             tick_en;
  logic             step;
  logic             wrap;

  assign tick_en = tick && ctrl_q.on;

  pt_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_period(wr_period),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .ctrl_o   (ctrl_q),
    .period_o (period_q)
  );

  pt_prescaler u_pre (
    .clk    (clk),
    .rst    (rst),
    .tick_en(tick_en),
    .clear  (wr_count),
    .sel    (ctrl_q.pre_sel),
    .cnt_o  (prescale_cnt_o),
    .step_o (step)
  );

  pt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .step_i    (step),
    .load_i    (wr_count),
    .load_val_i(wr_data),
    .period_i  (period_q),
    .count_o   (count_o),
    .wrap_o    (wrap),
    .match_o   (match_o)
  );

  pt_postscaler u_post (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (wrap),
    .clear  (wr_count),
    .sel    (ctrl_q.post_sel),
    .irq_clr(irq_clr),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run_on,
  input logic             wr_count,
  input logic [CNT_W-1:0] wr_data,
  input logic             irq_clr,
  input logic [CNT_W-1:0] count_o,
  input logic [3:0]       prescale_cnt_o,
  input logic             match_o,
  input logic             irq_o
);

  // R2: without an enabled tick or a load the count holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!(tick && run_on) && !wr_count) |=> $stable(count_o));

  // R4: a match pulse always sees a count of zero
  a_r4_match_zero: assert property (@(posedge clk) disable iff (rst)
    match_o |-> (count_o == '0));

  // R6: the flag rises only together with a match pulse
  a_r6_irq_on_match: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> match_o);

  // R7: a clear always wins
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
    irq_clr |=> !irq_o);

  // R7: the flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !irq_clr) |=> irq_o);

  // R8: a count write loads the data and clears the prescaler
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> ((count_o == $past(wr_data)) && (prescale_cnt_o == 4'd0)));

endmodule

bind period_timer period_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick          (tick),
  .run_on        (ctrl_q.on),
  .wr_count      (wr_count),
  .wr_data       (wr_data),
  .irq_clr       (irq_clr),
  .count_o       (count_o),
  .prescale_cnt_o(prescale_cnt_o),
  .match_o       (match_o),
  .irq_o         (irq_o)
);

// File: tb/period_timer_bench.sv
`timescale 1ns/1ps
module period_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_count = 1'b0;
  logic       wr_period = 1'b0;
  logic       wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq_clr = 1'b0;
  logic [7:0] count_o;
  logic [3:0] prescale_cnt_o;
  logic       match_o;
  logic       irq_o;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  period_timer #(.CNT_W(8)) u_period_timer (
    .clk(clk), .rst(rst), .tick(tick), .wr_count(wr_count),
    .wr_period(wr_period), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
    .irq_clr(irq_clr), .count_o(count_o), .prescale_cnt_o(prescale_cnt_o),
    .match_o(match_o), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic w_ctrl(input bit on, input int pre, input int post);
    wr_data = 8'((post << 3) | (pre << 1) | int'(on));
    wr_ctrl = 1'b1;
    step(1);
    wr_ctrl = 1'b0;
  endtask

  task automatic w_per(input int v);
    wr_data = 8'(v);
    wr_period = 1'b1;
    step(1);
    wr_period = 1'b0;
  endtask

  task automatic w_cnt(input int v, input bit clr);
    wr_data = 8'(v);
    wr_count = 1'b1;
    irq_clr = clr;
    step(1);
    wr_count = 1'b0;
    irq_clr = 1'b0;
  endtask

  function automatic int ratio(input int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : 16;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int per_set[4];
    int post_set[3];
    per_set  = '{0, 1, 3, 7};
    post_set = '{0, 2, 5};

    @(negedge clk);
    step(2);
    rst = 1'b0;
    // R1 reset state
    check(count_o == 0, "R1 count", count_o, 0);
    check(prescale_cnt_o == 0, "R1 prescale", prescale_cnt_o, 0);
    check(match_o == 0 && irq_o == 0, "R1 match/irq", {match_o, irq_o}, 0);
    tick = 1'b1;
    step(5);
    check(count_o == 0, "R1 run bit clear holds count", count_o, 0);

    // R2 tick gating and run bit
    w_per(200);
    w_ctrl(1, 0, 0);
    w_cnt(10, 1);
    tick = 1'b0;
    step(5);
    check(count_o == 10, "R2 tick low holds", count_o, 10);
    tick = 1'b1;
    step(3);
    check(count_o == 13, "R2 tick high advances", count_o, 13);
    w_ctrl(0, 0, 0);
    check(count_o == 14, "R2 last step before stop", count_o, 14);
    step(4);
    check(count_o == 14, "R2 run bit clear holds", count_o, 14);

    // R3 prescaler readback 1:4
    w_ctrl(1, 1, 0);
    w_cnt(0, 1);
    step(3);
    check(prescale_cnt_o == 3 && count_o == 0, "R3 prescale count 3", prescale_cnt_o, 3);
    step(1);
    check(prescale_cnt_o == 0 && count_o == 1, "R3 prescale wrap steps count", count_o, 1);

    // R9 control write keeps prescaler count
    step(2);
    w_ctrl(1, 1, 0);
    check(prescale_cnt_o == 3, "R9 prescale kept", prescale_cnt_o, 3);

    // R8 count write loads value and clears prescaler
    step(2);
    w_cnt(77, 0);
    check(count_o == 77 && prescale_cnt_o == 0, "R8 load and clear", {count_o, prescale_cnt_o}, {8'd77, 4'd0});

    // R9 control write keeps postscaler count (match every cycle, 1:4 post)
    w_per(0);
    w_ctrl(1, 0, 3);
    w_cnt(0, 1);
    step(2);
    w_ctrl(1, 0, 3);
    check(irq_o == 0, "R9 flag not yet after 3 matches", irq_o, 0);
    step(1);
    check(irq_o == 1, "R9 flag at 4th match", irq_o, 1);

    // R8 count write clears postscaler count
    w_cnt(0, 1);
    step(2);
    w_cnt(0, 0);
    step(3);
    check(irq_o == 0, "R8 postscaler restarted", irq_o, 0);
    step(1);
    check(irq_o == 1, "R8 flag after 4 fresh matches", irq_o, 1);

    // R7 clear wins over a coincident set, then sets again
    w_ctrl(1, 0, 0);
    irq_clr = 1'b1;
    step(1);
    irq_clr = 1'b0;
    check(irq_o == 0 && match_o == 1, "R7 clear wins", irq_o, 0);
    step(1);
    check(irq_o == 1, "R7 sets again", irq_o, 1);

    // R7 sticky while no matches
    w_per(50);
    w_cnt(50, 1);
    step(1);
    check(irq_o == 1 && match_o == 1, "R7 set on match", irq_o, 1);
    step(10);
    check(irq_o == 1 && match_o == 0, "R7 sticky", irq_o, 1);

    // R5 roll through maximum without a match
    begin
      int seen;
      seen = 0;
      w_per(3);
      w_cnt(250, 1);
      for (int n = 1; n <= 9; n++) begin
        step(1);
        if (match_o) seen++;
      end
      check(seen == 0 && count_o == 3, "R5 no match on rollover", seen, 0);
      step(1);
      check(match_o == 1 && count_o == 0, "R5 match at period", match_o, 1);
    end

    // R10 period change takes effect
    w_per(9);
    w_cnt(0, 1);
    w_per(2);
    step(1);
    check(match_o == 0 && count_o == 2, "R10 before new period match", count_o, 2);
    step(1);
    check(match_o == 1, "R10 match at new period", match_o, 1);

    // Sweep: R3, R4, R6
    for (int ps = 0; ps < 4; ps++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int qi = 0; qi < 3; qi++) begin
          int d, nirq, lim, m1, m2, fi;
          d    = ratio(ps) * (per_set[pi] + 1);
          nirq = d * (post_set[qi] + 1);
          lim  = (nirq > 2 * d) ? nirq : 2 * d;
          m1 = -1; m2 = -1; fi = -1;
          w_ctrl(0, 0, 0);
          w_per(per_set[pi]);
          w_ctrl(1, ps, post_set[qi]);
          w_cnt(0, 1);
          for (int n = 1; n <= lim; n++) begin
            step(1);
            if (match_o) begin
              if (m1 < 0) m1 = n;
              else if (m2 < 0) m2 = n;
            end
            if (irq_o && fi < 0) fi = n;
          end
          check(m1 == d, "R4 first match time", m1, d);
          check(m2 - m1 == d, "R3 match interval", m2 - m1, d);
          check(fi == nirq, "R6 flag time", fi, nirq);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule